// File: doc/BRIEF.md
# Instruction Prefetch Queue with Branch-Target Fill

This block sits between an instruction memory port and a decode stage. A sequential program counter, separate from the branch target arithmetic, requests aligned 32-bit fetch words ahead of decode and parks the returned words in a four-slot queue. A slot holds either one 32-bit instruction or two 16-bit instructions. Decode takes one instruction per accepted valid/ready handshake. Halfword pairs are split and handed over low half first.

A taken branch redirects fetch to a target formed by a dedicated adder. All queued words are dropped, and any fetch responses still due from the old path are discarded when they arrive. When a branch-target-buffer hit supplies the target word together with the redirect, that word enters the queue at once. Decode then sees it in the very next cycle, and sequential fetch continues from the word after it. Without such a hit, the target word comes from memory and decode sees a single empty cycle after the branch cycle. A branch that resolves not-taken changes nothing.

Memory responses return in request order with a latency of one or more cycles.

Top module: `ifetch_queue`

## Requirements
- R1: In the first cycle after reset, `dec_valid` is 0 and `imem_req` is 1 with `imem_addr` equal to the reset address (default 0x0000_1000).
- R2: Outside a redirect, successive fetch requests use addresses that rise by exactly 4, and returned words reach decode in request order.
- R3: A sequential request is made only while occupied slots plus live outstanding fetches are fewer than 4, and the total of all outstanding fetches, stale ones included, stays below 8. Requests resume as soon as space frees.
- R4: A fetch word whose bit 0 is 1 holds two 16-bit instructions. The low halfword issues first at the word's address, then the high halfword at address+2. Each has `dec_is16`=1 and is zero-extended in `dec_insn`. A word with bit 0 equal to 0 issues once as a 32-bit instruction with `dec_is16`=0.
- R5: The presented instruction advances only on a cycle with `dec_valid` and `dec_ready` both high. Otherwise it holds its value.
- R6: A branch with `br_valid`=1 and `br_taken`=0 has no effect on the queue, the presented instruction or the fetch stream.
- R7: The redirect target is `br_base + br_disp` with the two low bits forced to 0.
- R8: On a taken branch without a target hit, `dec_valid` is 0 in the branch cycle and a request to the target goes out in that same cycle. If memory returns the target word in the next cycle, decode sees it one cycle later, after a single empty cycle.
- R9: On a taken branch with `btb_hit`=1, `btb_word` is presented at the target address in the next cycle, and the request made in the branch cycle is for target+4.
- R10: Responses to requests issued before a taken branch are never presented to decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_req | output | 1 | Fetch request this cycle |
| imem_addr | output | AW | Word-aligned fetch address |
| imem_rvalid | input | 1 | Fetch response valid (in order) |
| imem_rdata | input | 32 | Fetch response word |
| dec_valid | output | 1 | Instruction offered to decode |
| dec_ready | input | 1 | Decode accepts the offered instruction |
| dec_insn | output | 32 | Instruction, 16-bit ones zero-extended |
| dec_is16 | output | 1 | Offered instruction is 16 bits |
| dec_pc | output | AW | Address of the offered instruction |
| br_valid | input | 1 | A branch resolves this cycle |
| br_taken | input | 1 | The resolving branch is taken |
| br_base | input | AW | Target adder base operand |
| br_disp | input | AW | Target adder displacement operand |
| btb_hit | input | 1 | Target word supplied with the redirect |
| btb_word | input | 32 | Supplied target word |

## Verification
A bad slot pointer or occupancy count shows at decode on the next handshake, as a repeated, skipped or misplaced address. A stale-response counter that is off by one either shows an old-path word right after a redirect or swallows the first target word, so `dec_pc` goes wrong within a few cycles of the branch. A halfword-phase error shows as a wrong `dec_pc` bit 1 or as a pair member delivered twice, on the very next issue. A wrong space count shows at once on `imem_req`, which the bench compares every cycle against an independent model.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;

  typedef enum logic {HALF_LOW = 1'b0, HALF_HIGH = 1'b1} half_sel_e;

  function automatic logic word_is_pair(input logic [WORD_W-1:0] w);
    return w[0];
  endfunction
endpackage

// File: rtl/pfq_target_adder.sv
module pfq_target_adder #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] disp,
  output logic [AW-1:0] target
);
  logic [AW-1:0] sum;
  always_comb begin
    sum    = base + disp;
    target = {sum[AW-1:2], 2'b00};
  end
endmodule

// File: rtl/pfq_fetch_ctrl.sv
module pfq_fetch_ctrl #(
  parameter int unsigned   AW       = 32,
  parameter int unsigned   DEPTH    = 4,
  parameter logic [AW-1:0] RESET_PC = 32'h0000_1000,
  parameter int unsigned   CW       = $clog2(DEPTH + 1),
  parameter int unsigned   IFW      = $clog2(2 * DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           redirect,
  input  logic           btb_hit,
  input  logic [AW-1:0]  target,
  input  logic           rvalid,
  input  logic [CW-1:0]  occ,
  output logic           req,
  output logic [AW-1:0]  addr,
  output logic           accept,
  output logic [AW-1:0]  resp_pc,
  output logic [IFW-1:0] live_cnt
);
  localparam int unsigned MAXF = 2 * DEPTH;
  localparam int unsigned SW   = IFW + 1;

  logic [AW-1:0]  pc_q, resp_pc_q, redir_addr;
  logic [IFW-1:0] inflight_q, drop_q;
  logic           space_ok, room_ok;

  always_comb begin
    live_cnt   = inflight_q - drop_q;
    redir_addr = btb_hit ? target + AW'(4) : target;
    space_ok   = (SW'(occ) + SW'(live_cnt)) < SW'(DEPTH);
    room_ok    = inflight_q < IFW'(MAXF);
    req        = (redirect | space_ok) & room_ok;
    addr       = redirect ? redir_addr : pc_q;
    accept     = rvalid & (drop_q == '0) & ~redirect;
    resp_pc    = resp_pc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= RESET_PC;
      resp_pc_q  <= RESET_PC;
      inflight_q <= '0;
      drop_q     <= '0;
    end else begin
      if (req)           pc_q <= addr + AW'(4);
      else if (redirect) pc_q <= redir_addr;

      inflight_q <= inflight_q - IFW'(rvalid) + IFW'(req);

      if (redirect)                      drop_q <= inflight_q - IFW'(rvalid);
      else if (rvalid && drop_q != '0)   drop_q <= drop_q - IFW'(1);

      if (redirect)    resp_pc_q <= redir_addr;
      else if (accept) resp_pc_q <= resp_pc_q + AW'(4);
    end
  end
endmodule

// File: rtl/pfq_buffer.sv
module pfq_buffer
  import pfq_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [AW-1:0]     wr_pc,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_insn,
  output logic              rd_is16,
  output logic [AW-1:0]     rd_pc,
  output logic [CW-1:0]     occ
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] word_mem [DEPTH];
  logic [AW-1:0]     pc_mem   [DEPTH];
  logic [PW-1:0]     wr_ptr_q, rd_ptr_q, waddr;
  logic [CW-1:0]     occ_q;
  half_sel_e         half_q;
  logic [WORD_W-1:0] hd_word;
  logic [AW-1:0]     hd_pc;
  logic              hd_pair, fire, pop;

  assign waddr = flush ? '0 : wr_ptr_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      word_mem[waddr] <= wr_word;
      pc_mem[waddr]   <= wr_pc;
    end
  end

  always_comb begin
    hd_word  = word_mem[rd_ptr_q];
    hd_pc    = pc_mem[rd_ptr_q];
    hd_pair  = word_is_pair(hd_word);
    rd_valid = (occ_q != '0) & ~flush;
    fire     = rd_valid & rd_ready;
    pop      = fire & (~hd_pair | (half_q == HALF_HIGH));
    occ      = occ_q;
    if (!hd_pair) begin
      rd_insn = hd_word;
      rd_is16 = 1'b0;
      rd_pc   = hd_pc;
    end else if (half_q == HALF_LOW) begin
      rd_insn = {{HALF_W{1'b0}}, hd_word[HALF_W-1:0]};
      rd_is16 = 1'b1;
      rd_pc   = hd_pc;
    end else begin
      rd_insn = {{HALF_W{1'b0}}, hd_word[WORD_W-1:HALF_W]};
      rd_is16 = 1'b1;
      rd_pc   = hd_pc + AW'(2);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
      half_q   <= HALF_LOW;
    end else if (flush) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= wr_en ? PW'(1) : '0;
      occ_q    <= wr_en ? CW'(1) : '0;
      half_q   <= HALF_LOW;
    end else begin
      if (wr_en) wr_ptr_q <= wr_ptr_q + PW'(1);
      if (pop)   rd_ptr_q <= rd_ptr_q + PW'(1);
      occ_q <= occ_q + CW'(wr_en) - CW'(pop);
      if (fire) half_q <= (hd_pair && half_q == HALF_LOW) ? HALF_HIGH : HALF_LOW;
    end
  end
endmodule

// File: rtl/ifetch_queue.sv
module ifetch_queue
  import pfq_pkg::*;
#(
  parameter int unsigned   AW       = 32,
  parameter int unsigned   DEPTH    = 4,
  parameter logic [AW-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  output logic              imem_req,
  output logic [AW-1:0]     imem_addr,
  input  logic              imem_rvalid,
  input  logic [WORD_W-1:0] imem_rdata,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic [WORD_W-1:0] dec_insn,
  output logic              dec_is16,
  output logic [AW-1:0]     dec_pc,
  input  logic              br_valid,
  input  logic              br_taken,
  input  logic [AW-1:0]     br_base,
  input  logic [AW-1:0]     br_disp,
  input  logic              btb_hit,
  input  logic [WORD_W-1:0] btb_word
);
  localparam int unsigned CW  = $clog2(DEPTH + 1);
  localparam int unsigned IFW = $clog2(2 * DEPTH + 1);

  logic              redirect, accept, wr_en;
  logic [AW-1:0]     target, resp_pc, wr_pc;
  logic [WORD_W-1:0] wr_word;
  logic [CW-1:0]     occ;
  logic [IFW-1:0]    live_cnt;

  assign redirect = br_valid & br_taken;
  assign wr_en    = redirect ? btb_hit : accept;
  assign wr_word  = redirect ? btb_word : imem_rdata;
  assign wr_pc    = redirect ? target : resp_pc;

  pfq_target_adder #(.AW(AW)) tgt_i (
    .base(br_base), .disp(br_disp), .target(target)
  );

  pfq_fetch_ctrl #(.AW(AW), .DEPTH(DEPTH), .RESET_PC(RESET_PC)) fctl_i (
    .clk(clk), .rst(rst), .redirect(redirect), .btb_hit(btb_hit),
    .target(target), .rvalid(imem_rvalid), .occ(occ),
    .req(imem_req), .addr(imem_addr), .accept(accept),
    .resp_pc(resp_pc), .live_cnt(live_cnt)
  );

  pfq_buffer #(.AW(AW), .DEPTH(DEPTH)) buf_i (
    .clk(clk), .rst(rst), .flush(redirect), .wr_en(wr_en),
    .wr_word(wr_word), .wr_pc(wr_pc), .rd_ready(dec_ready),
    .rd_valid(dec_valid), .rd_insn(dec_insn), .rd_is16(dec_is16),
    .rd_pc(dec_pc), .occ(occ)
  );
endmodule

// File: rtl/ifetch_queue_chk.sv
module ifetch_queue_chk #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = $clog2(DEPTH + 1),
  parameter int unsigned IFW   = $clog2(2 * DEPTH + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           br_valid,
  input logic           br_taken,
  input logic           btb_hit,
  input logic [AW-1:0]  br_base,
  input logic [AW-1:0]  br_disp,
  input logic           imem_req,
  input logic [AW-1:0]  imem_addr,
  input logic           dec_valid,
  input logic           dec_ready,
  input logic [31:0]    dec_insn,
  input logic           dec_is16,
  input logic [AW-1:0]  dec_pc,
  input logic [CW-1:0]  occ,
  input logic [IFW-1:0] live_cnt
);
  logic          armed;
  logic          taken;
  logic [AW-1:0] exp_tgt;

  assign taken   = br_valid & br_taken;
  assign exp_tgt = (br_base + br_disp) & ~AW'(3);

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !dec_valid);

  p_seq_addr_r2: assert property (@(posedge clk) disable iff (rst)
    armed && $past(imem_req) && imem_req && !taken |-> imem_addr == $past(imem_addr) + AW'(4));

  p_occ_bound_r3: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= int'(DEPTH));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    imem_req && !taken |-> int'(occ) + int'(live_cnt) < int'(DEPTH));

  p_single_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    dec_valid && !dec_is16 |-> dec_pc[1:0] == 2'b00 && !dec_insn[0]);

  p_half_zext_r4: assert property (@(posedge clk) disable iff (rst)
    dec_valid && dec_is16 |-> dec_insn[31:16] == 16'h0);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    dec_valid && !dec_ready && !taken |=> taken || (dec_valid && $stable(dec_pc) && $stable(dec_insn)));

  p_target_req_r7: assert property (@(posedge clk) disable iff (rst)
    taken && !btb_hit && imem_req |-> imem_addr == exp_tgt);

  p_kill_r8: assert property (@(posedge clk) disable iff (rst)
    taken |-> !dec_valid);

  p_btb_next_r9: assert property (@(posedge clk) disable iff (rst)
    taken && btb_hit |=> taken || (dec_valid && dec_pc == $past(exp_tgt)));
endmodule

bind ifetch_queue ifetch_queue_chk #(.AW(AW), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .br_valid(br_valid), .br_taken(br_taken),
  .btb_hit(btb_hit), .br_base(br_base), .br_disp(br_disp),
  .imem_req(imem_req), .imem_addr(imem_addr), .dec_valid(dec_valid),
  .dec_ready(dec_ready), .dec_insn(dec_insn), .dec_is16(dec_is16),
  .dec_pc(dec_pc), .occ(occ), .live_cnt(live_cnt)
);

// File: tb/ifetch_queue_tb_top.sv
module ifetch_queue_tb_top;
  localparam int unsigned DEPTH = 4;
  localparam logic [31:0] RPC   = 32'h0000_1000;

  logic        clk = 1'b0, rst = 1'b1;
  logic        imem_req, imem_rvalid = 1'b0;
  logic [31:0] imem_addr, imem_rdata = 32'h0;
  logic        dec_valid, dec_ready = 1'b0, dec_is16;
  logic [31:0] dec_insn, dec_pc;
  logic        br_valid = 1'b0, br_taken = 1'b0, btb_hit = 1'b0;
  logic [31:0] br_base = 32'h0, br_disp = 32'h0, btb_word = 32'h0;

  always #5 clk = ~clk;

  ifetch_queue #(.AW(32), .DEPTH(DEPTH), .RESET_PC(RPC)) dut_i (.*);

  int checks = 0, fails = 0;

  // stimulus controls
  bit          d_ready, d_bv, d_bt, d_btb;
  logic [31:0] d_base, d_disp, d_btbw;
  int          mem_rate = 100;

  // bench memory and reference model state
  logic [31:0] memq[$];
  logic [31:0] mq_w[$], mq_pc[$];
  logic [31:0] pend_a[$];
  bit          pend_st[$];
  bit          lo_done;
  logic [31:0] mpc;

  // last observed outputs
  bit          o_v, o_req, o_is16;
  logic [31:0] o_addr, o_pc, o_insn;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[17:2] ^ 16'h3C5A, a[16:2], a[2] ^ a[3] ^ a[5]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic body();
    bit redir, exp_req, exp_v;
    int live;
    logic [31:0] tgt, exp_addr, w, e_insn, e_pc;
    bit e16;
    logic [31:0] ra;
    bit rs;
    dec_ready = d_ready; br_valid = d_bv; br_taken = d_bt;
    br_base = d_base; br_disp = d_disp; btb_hit = d_btb; btb_word = d_btbw;
    if (memq.size() > 0 && $urandom_range(99) < mem_rate) begin
      imem_rvalid = 1'b1; imem_rdata = memf(memq[0]); void'(memq.pop_front());
    end else begin
      imem_rvalid = 1'b0; imem_rdata = 32'h0;
    end
    #1;
    redir = d_bv && d_bt;
    tgt   = (d_base + d_disp) & ~32'h3;
    live  = 0;
    foreach (pend_st[i]) if (!pend_st[i]) live++;
    exp_req  = (redir || (mq_w.size() + live < DEPTH)) && (pend_a.size() < 2 * DEPTH);
    exp_addr = redir ? (d_btb ? tgt + 32'd4 : tgt) : mpc;
    exp_v    = !redir && mq_w.size() > 0;
    chk("R3 imem_req", 64'(imem_req), 64'(exp_req));
    if (exp_req) chk(redir ? "R8 imem_addr at redirect" : "R2 imem_addr", 64'(imem_addr), 64'(exp_addr));
    chk(redir ? "R8 dec_valid in branch cycle" : "R5 dec_valid", 64'(dec_valid), 64'(exp_v));
    if (exp_v) begin
      w = mq_w[0];
      if (!w[0])        begin e_insn = w;                e16 = 1'b0; e_pc = mq_pc[0]; end
      else if (!lo_done) begin e_insn = {16'h0, w[15:0]};  e16 = 1'b1; e_pc = mq_pc[0]; end
      else              begin e_insn = {16'h0, w[31:16]}; e16 = 1'b1; e_pc = mq_pc[0] + 32'd2; end
      chk("R4 dec_insn", 64'(dec_insn), 64'(e_insn));
      chk("R4 dec_is16", 64'(dec_is16), 64'(e16));
      chk("R2 dec_pc",   64'(dec_pc),   64'(e_pc));
    end
    o_v = dec_valid; o_req = imem_req; o_addr = imem_addr;
    o_pc = dec_pc; o_insn = dec_insn; o_is16 = dec_is16;
    if (imem_req) memq.push_back(imem_addr);
    // reference model update
    if (exp_v && d_ready) begin
      if (mq_w[0][0] && !lo_done) lo_done = 1'b1;
      else begin void'(mq_w.pop_front()); void'(mq_pc.pop_front()); lo_done = 1'b0; end
    end
    if (imem_rvalid && pend_a.size() > 0) begin
      ra = pend_a.pop_front(); rs = pend_st.pop_front();
      if (!redir && !rs) begin mq_w.push_back(memf(ra)); mq_pc.push_back(ra); end
    end
    if (redir) begin
      foreach (pend_st[i]) pend_st[i] = 1'b1;
      mq_w.delete(); mq_pc.delete(); lo_done = 1'b0;
      if (d_btb) begin mq_w.push_back(d_btbw); mq_pc.push_back(tgt); end
    end
    if (exp_req) begin
      pend_a.push_back(exp_addr); pend_st.push_back(1'b0); mpc = exp_addr + 32'd4;
    end else if (redir) mpc = exp_addr;
  endtask

  task automatic step();
    @(negedge clk);
    body();
  endtask

  task automatic no_br();
    d_bv = 1'b0; d_bt = 1'b0; d_btb = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] hold_pc;
    no_br(); d_ready = 1'b0; d_base = 0; d_disp = 0; d_btbw = 0;
    mpc = RPC; lo_done = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    body();
    chk("R1 dec_valid after reset", 64'(o_v), 64'd0);
    chk("R1 imem_req after reset", 64'(o_req), 64'd1);
    chk("R1 first address", 64'(o_addr), 64'(RPC));

    d_ready = 1'b1; mem_rate = 100;
    repeat (40) step();

    d_ready = 1'b0;
    repeat (20) step();
    chk("R3 no request while full", 64'(o_req), 64'd0);
    chk("R5 head held", 64'(o_v), 64'd1);
    hold_pc = o_pc;

    d_bv = 1'b1; d_bt = 1'b0; d_base = 32'h0000_8000; d_disp = 32'h10;
    step(); no_br(); step();
    chk("R6 not-taken keeps head", 64'(o_pc), 64'(hold_pc));
    chk("R6 not-taken keeps valid", 64'(o_v), 64'd1);
    chk("R6 not-taken no request", 64'(o_req), 64'd0);

    d_ready = 1'b1;
    d_bv = 1'b1; d_bt = 1'b1; d_base = 32'h0000_2001; d_disp = 32'h0000_0102;
    step();
    chk("R7 target address", 64'(o_addr), 64'h2100);
    chk("R8 branch cycle empty", 64'(o_v), 64'd0);
    no_br(); step();
    chk("R8 single bubble", 64'(o_v), 64'd0);
    step();
    chk("R8 target presented", 64'(o_v), 64'd1);
    chk("R8 target pc", 64'(o_pc), 64'h2100);

    mem_rate = 0;
    repeat (4) step();
    d_bv = 1'b1; d_bt = 1'b1; d_base = 32'h0000_4000; d_disp = 32'h0;
    step(); no_br(); mem_rate = 100;
    for (int i = 0; i < 30 && !o_v; i++) step();
    chk("R10 first issue after stale drops", 64'(o_pc), 64'h4000);

    d_ready = 1'b0;
    repeat (20) step();
    d_ready = 1'b1;
    d_bv = 1'b1; d_bt = 1'b1; d_btb = 1'b1; d_base = 32'h0000_3000; d_disp = 32'h40;
    d_btbw = 32'h1234_5670;
    step();
    chk("R9 request target+4", 64'(o_addr), 64'h3044);
    no_br(); step();
    chk("R9 hit word valid", 64'(o_v), 64'd1);
    chk("R9 hit word pc", 64'(o_pc), 64'h3040);
    chk("R9 hit word insn", 64'(o_insn), 64'h1234_5670);

    d_bv = 1'b1; d_bt = 1'b1; d_btb = 1'b1; d_base = 32'h0000_5000; d_disp = 32'h0;
    d_btbw = 32'hBEEF_1235;
    step(); no_br(); step();
    chk("R4 low half first", 64'(o_insn), 64'h1235);
    chk("R4 low half pc", 64'(o_pc), 64'h5000);
    chk("R4 low half is16", 64'(o_is16), 64'd1);
    step();
    chk("R4 high half second", 64'(o_insn), 64'hBEEF);
    chk("R4 high half pc", 64'(o_pc), 64'h5002);

    mem_rate = 70;
    for (int n = 0; n < 4000; n++) begin
      d_ready = ($urandom_range(99) < 75);
      d_bv = ($urandom_range(99) < 4);
      d_bt = ($urandom_range(99) < 70);
      d_btb = ($urandom_range(1) == 1);
      d_base = $urandom; d_disp = $urandom & 32'hFFFF;
      d_btbw = $urandom;
      step();
    end
    no_br();
    summary();
    $finish;
  end
endmodule